// File: doc/BRIEF.md
# Watchdog Timer with Shared Control Register

This block is a watchdog counter advanced by a low-speed tick of 32.768 kHz. It raises a one-cycle non-maskable interrupt request when software fails to restart it in time. One 8-bit control register drives it. The same register also holds the clock-output frequency select, the clock-output on/off bit, the clock-timer run bit and a clock-timer reset strobe. These fields go out as plain outputs to logic outside this block.

Software writes the register through a synchronous write strobe and reads it at any time on a read-data bus. The watchdog comes out of reset already enabled. Software must therefore either restart it regularly or disable it.

A small state machine tracks the watchdog. It has three states. ST_HALT means counting is off. ST_RUN means counting is on. ST_FIRE is a single cycle that drives the NMI request. The state machine has these transitions:
- HALT to RUN when the enable bit is set.
- RUN to HALT when the enable bit is cleared.
- RUN or HALT to FIRE when the count expires.
- FIRE back to RUN or HALT on the next cycle, according to the enable bit.

Top module: `wdt_top`

## Requirements
- R1: After reset, read data is 8'h80, meaning the enable bit (bit 7) is 1 and every other field is 0. All outputs are 0, including the NMI request.
- R2: Bit 7 is the watchdog enable. It is written from wr_data[7] on each write and reads back its stored value.
- R3: Bit 2 is the restart bit. Writing 1 clears the count in that cycle. Writing 0 has no effect. It always reads 0.
- R4: While enabled, each tick advances a CNT_W-bit count. The tick that finds the count at its maximum (2^CNT_W-1) wraps it to 0, and nmi_req is high during the following cycle.
- R5: A restart write in the same cycle as a tick wins. The count becomes 0 and no NMI results from that tick.
- R6: While the enable bit is 0, ticks are ignored and no NMI is raised. The count is held, and counting resumes from the held value once the bit is set again.
- R7: Bits 6:4 (frequency select, codes 0-3 for the fast clock /8,/4,/2,/1 and codes 4-7 for the slow clock /8,/4,/2,/1) and bit 3 (clock-output on) are read/write. They reset to 0 and drive fout_sel and fout_on.
- R8: Bit 0 is the read/write clock-timer run bit, reset to 0, and drives ctmr_run. Writing 1 to bit 1 gives a one-cycle ctmr_rst pulse in the next cycle. Bit 1 always reads 0.
- R9: nmi_req is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| tick | input | 1 | Low-speed clock enable, one cycle per slow period |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| fout_sel | output | 3 | Clock-output frequency select |
| fout_on | output | 1 | Clock-output enable |
| ctmr_run | output | 1 | Clock-timer run control |
| ctmr_rst | output | 1 | One-cycle clock-timer reset pulse |

## Verification
The assertions assume the following about the inputs:
- tick is a single-cycle strobe that is valid only outside reset.
- wr_en and wr_data are stable across each clock edge.
- CNT_W is at least 2, so an expiry can never follow an expiry directly.

The stimulus is changed only on falling edges and is built from tick patterns of every cycle, every third cycle and none at all. The bench uses a 6-bit count so that full expiry periods fit easily. It places restart and enable writes both on tick cycles and away from them, including a restart exactly on the expiring tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int REG_W    = 8;
    localparam int B_EN     = 7;
    localparam int B_FSEL_H = 6;
    localparam int B_FSEL_L = 4;
    localparam int B_FON    = 3;
    localparam int B_KICK   = 2;
    localparam int B_CTRST  = 1;
    localparam int B_CTRUN  = 0;
    localparam int FSEL_W   = B_FSEL_H - B_FSEL_L + 1;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wdt_state_e;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic              wd_en,
    output logic              kick,
    output logic [FSEL_W-1:0] fsel,
    output logic              fon,
    output logic              ct_run,
    output logic              ct_rst,
    output logic [REG_W-1:0]  rd_data
);
    logic              en_q;
    logic [FSEL_W-1:0] fsel_q;
    logic              fon_q;
    logic              run_q;
    logic              ctrst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b1;
            fsel_q  <= '0;
            fon_q   <= 1'b0;
            run_q   <= 1'b0;
            ctrst_q <= 1'b0;
        end else begin
            ctrst_q <= wr_en & wr_data[B_CTRST];
            if (wr_en) begin
                en_q   <= wr_data[B_EN];
                fsel_q <= wr_data[B_FSEL_H:B_FSEL_L];
                fon_q  <= wr_data[B_FON];
                run_q  <= wr_data[B_CTRUN];
            end
        end
    end

    always_comb begin
        rd_data                    = '0;
        rd_data[B_EN]              = en_q;
        rd_data[B_FSEL_H:B_FSEL_L] = fsel_q;
        rd_data[B_FON]             = fon_q;
        rd_data[B_CTRUN]           = run_q;
    end

    assign wd_en  = en_q;
    assign kick   = wr_en & wr_data[B_KICK];
    assign fsel   = fsel_q;
    assign fon    = fon_q;
    assign ct_run = run_q;
    assign ct_rst = ctrst_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic kick,
    output logic nmi
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    wdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             expire;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (kick) begin
            cnt_d = '0;
        end else if (en && tick) begin
            if (cnt_q == CNT_MAX) begin
                cnt_d  = '0;
                expire = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (expire)  state_d = ST_FIRE;
                else if (en) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (expire)   state_d = ST_FIRE;
                else if (!en) state_d = ST_HALT;
            end
            ST_FIRE: begin
                if (expire)  state_d = ST_FIRE;
                else if (en) state_d = ST_RUN;
                else         state_d = ST_HALT;
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        nmi = (state_q == ST_FIRE);
    end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       tick,
    output logic       nmi_req,
    output logic [2:0] fout_sel,
    output logic       fout_on,
    output logic       ctmr_run,
    output logic       ctmr_rst
);
    logic wd_en;
    logic kick;

    wdt_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wd_en   (wd_en),
        .kick    (kick),
        .fsel    (fout_sel),
        .fon     (fout_on),
        .ct_run  (ctmr_run),
        .ct_rst  (ctmr_rst),
        .rd_data (rd_data)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (wd_en),
        .tick  (tick),
        .kick  (kick),
        .nmi   (nmi_req)
    );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       tick,
    input logic       nmi_req,
    input logic       ctmr_rst
);
    // R9
    nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);

    // R4
    nmi_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> $past(tick));

    // R6
    nmi_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> $past(rd_data[7]));

    // R5
    kick_blocks_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[2]) |=> !nmi_req);

    // R2
    en_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[7] == $past(wr_data[7])));

    // R8
    ctrst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[1]) |=> ctmr_rst);

    // R8
    ctrst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctmr_rst |-> $past(wr_en && wr_data[1]));
endmodule

bind wdt_top wdt_chk u_wdt_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .tick     (tick),
    .nmi_req  (nmi_req),
    .ctmr_rst (ctmr_rst)
);

// File: tb/test_wdt_top.sv
module test_wdt_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 6;
    localparam int MAXC       = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick = 1'b0;
    logic [7:0] rd_data;
    logic       nmi_req;
    logic [2:0] fout_sel;
    logic       fout_on;
    logic       ctmr_run;
    logic       ctmr_rst;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_top #(.CNT_W(CW)) i_wdt_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick(tick), .nmi_req(nmi_req),
        .fout_sel(fout_sel), .fout_on(fout_on),
        .ctmr_run(ctmr_run), .ctmr_rst(ctmr_rst)
    );

    // behavioural reference model
    int   m_cnt;
    bit   m_en, m_fon, m_run, m_nmi, m_ctrst;
    bit [2:0] m_fsel;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_en = 1; m_fsel = 0; m_fon = 0; m_run = 0;
            m_nmi = 0; m_ctrst = 0;
        end else begin
            m_nmi   = 0;
            m_ctrst = wr_en && wr_data[1];
            if (wr_en && wr_data[2]) m_cnt = 0;
            else if (m_en && tick) begin
                if (m_cnt == MAXC) begin m_cnt = 0; m_nmi = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (wr_en) begin
                m_en = wr_data[7]; m_fsel = wr_data[6:4];
                m_fon = wr_data[3]; m_run = wr_data[0];
            end
        end
    end

    int checks = 0;
    int fails = 0;
    int nmi_seen = 0;
    bit prev_nmi = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_rd();
        return {m_en, m_fsel, m_fon, 2'b00, m_run};
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(nmi_req == m_nmi, "R4/R5/R6 nmi_req", nmi_req, m_nmi);
            chk(rd_data == m_rd(), "R2/R3/R7/R8 rd_data", rd_data, m_rd());
            chk(fout_sel == m_fsel && fout_on == m_fon, "R7 fout", {fout_sel, fout_on}, {m_fsel, m_fon});
            chk(ctmr_run == m_run && ctmr_rst == m_ctrst, "R8 ctmr", {ctmr_run, ctmr_rst}, {m_run, m_ctrst});
            chk(!(nmi_req && prev_nmi), "R9 back-to-back nmi", nmi_req, 0);
            prev_nmi = nmi_req;
            if (nmi_req) nmi_seen++;
        end
    end

    task automatic step(input bit w, input logic [7:0] d, input bit t);
        @(negedge clk);
        wr_en = w; wr_data = d; tick = t;
    endtask

    task automatic ticks(input int n, input int every);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, (i % every) == 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        done = 1;
        fails++;
        $display("FAIL R4 watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_data == 8'h80, "R1 reset rd_data", rd_data, 8'h80);
        chk(nmi_req == 0 && fout_sel == 0 && fout_on == 0 && ctmr_run == 0 && ctmr_rst == 0,
            "R1 reset outputs", {nmi_req, fout_sel, fout_on, ctmr_run, ctmr_rst}, 0);

        // R4 expiry after full period of ticks, then wrap
        base = nmi_seen;
        ticks(MAXC, 1);
        idle(2);
        chk(nmi_seen == base, "R4 early nmi", nmi_seen - base, 0);
        ticks(1, 1);
        idle(2);
        chk(nmi_seen == base + 1, "R4 expiry nmi", nmi_seen - base, 1);
        ticks(MAXC + 1, 1);
        idle(2);
        chk(nmi_seen == base + 2, "R4 wrap second nmi", nmi_seen - base, 2);

        // R3 periodic restart prevents nmi; write of 0 to restart bit does nothing
        step(1'b1, 8'h84, 1'b0);
        base = nmi_seen;
        for (int k = 0; k < 5; k++) begin
            ticks(40, 1);
            step(1'b1, 8'h80, 1'b1);
            step(1'b1, 8'h84, 1'b0);
        end
        idle(2);
        chk(nmi_seen == base, "R3 restart prevents nmi", nmi_seen - base, 0);
        chk(rd_data[2] == 0, "R3 restart bit reads 0", rd_data[2], 0);

        // R5 restart on the expiring tick
        ticks(MAXC, 1);
        base = nmi_seen;
        step(1'b1, 8'h84, 1'b1);
        idle(3);
        chk(nmi_seen == base, "R5 restart wins over tick", nmi_seen - base, 0);

        // R6 disable holds count
        step(1'b1, 8'h84, 1'b0);
        ticks(40, 1);
        step(1'b1, 8'h00, 1'b0);
        base = nmi_seen;
        ticks(200, 1);
        idle(2);
        chk(nmi_seen == base, "R6 disabled no nmi", nmi_seen - base, 0);
        chk(rd_data[7] == 0, "R2 enable reads 0", rd_data[7], 0);
        step(1'b1, 8'h80, 1'b0);
        ticks(MAXC + 1 - 40 - 1, 1);
        idle(2);
        chk(nmi_seen == base, "R6 resume not yet", nmi_seen - base, 0);
        ticks(1, 1);
        idle(2);
        chk(nmi_seen == base + 1, "R6 resume from held count", nmi_seen - base, 1);

        // R7 / R8 fields
        step(1'b1, 8'hF9, 1'b0);
        idle(1);
        chk(fout_sel == 3'd7 && fout_on == 1 && ctmr_run == 1, "R7 fields set",
            {fout_sel, fout_on, ctmr_run}, {3'd7, 1'b1, 1'b1});
        step(1'b1, 8'hA2, 1'b0);
        step(1'b0, 8'h00, 1'b0);
        chk(ctmr_rst == 1, "R8 ctmr_rst pulse", ctmr_rst, 1);
        chk(rd_data == 8'hA0, "R8 reset bit reads 0", rd_data, 8'hA0);
        idle(1);
        chk(ctmr_rst == 0, "R8 pulse one cycle", ctmr_rst, 0);

        // sparse ticks, every third cycle, with enable set
        step(1'b1, 8'h84, 1'b0);
        base = nmi_seen;
        ticks(3 * (MAXC + 1) + 4, 3);
        idle(2);
        chk(nmi_seen == base + 1, "R4 sparse ticks nmi", nmi_seen - base, 1);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule